// File: doc/BRIEF.md
# Decode-Stage Forwarding and Hazard Unit

This block holds the hazard logic of a five-stage pipeline (fetch, decode, execute, memory, write-back) that has one memory for both instructions and data and a register file that writes on the clock edge. Operand forwarding is resolved at the end of decode. The two source operands that leave decode are therefore already correct, and branches compare those forwarded values in decode, so a resolved branch costs a single bubble.

The unit is combinational. It takes the decode-stage source register numbers and instruction class, the destination and write enable of each later stage, the data values that could be forwarded, and a flag for a data access in the memory stage. It returns the mux selects and the forwarded operand values. It also drives the program-counter enable and source, a hold for the fetch/decode register, a NOP-insert control for that register, a bubble control for the decode/execute register, and a conditional-branch-taken flag.

Top module: `decode_hazard_unit`

## Requirements
- R1: Each operand select is 2'b01 (memory-stage result) when the memory stage writes that source register. Otherwise it is 2'b10 (write-back value) when write-back writes that source register. Otherwise it is 2'b00 (register-file read). Register 0 is forwarded like any other register.
- R2: `opnd_a`/`opnd_b` equal the value picked by their select, and they follow the write-back data in the same cycle. Branch decisions use these forwarded values.
- R3: When the execute-stage instruction writes a register (load or ALU result) that decode reads with its use flag set, the unit stalls: `pc_en`=0, `ifid_hold`=1, `idex_bubble`=1, `ifid_nop`=0. A match on a source whose use flag is clear causes no stall.
- R4: A less-than branch is taken when forwarded `opnd_a` bit 15 is 1. An equal branch is taken when forwarded `opnd_a` is zero. When taken, `br_taken`=1 and `pc_sel`=2'b01.
- R5: Any redirect (taken branch, register jump, trap) gives `pc_en`=1 and `ifid_nop`=1, also during a memory-stage data access.
- R6: `pc_sel` encodes 2'b00 next sequential, 2'b01 branch target, 2'b10 register value (register jump), 2'b11 constant zero (trap). Priority is trap, then jump, then conditional branch.
- R7: A memory-stage data access with no redirect and no stall gives `pc_en`=0, `ifid_nop`=1, `idex_bubble`=0.
- R8: During a stall no redirect happens (`br_taken`=0, `pc_sel`=2'b00), and the hold overrides NOP insertion caused by a memory access.
- R9: With no hazard, no access and no control transfer: `pc_en`=1, `pc_sel`=2'b00, all other controls 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 3 | Decode first source register |
| id_rt | input | 3 | Decode second source register |
| id_use_rs | input | 1 | Decode reads first source |
| id_use_rt | input | 1 | Decode reads second source |
| id_blt | input | 1 | Decode holds less-than branch |
| id_beq | input | 1 | Decode holds equal branch |
| id_jr | input | 1 | Decode holds register jump |
| id_trap | input | 1 | Decode holds trap to address zero |
| ex_rd | input | 3 | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage writes a register |
| mem_rd | input | 3 | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage writes a register |
| mem_access | input | 1 | Memory stage uses the shared memory this cycle |
| wb_rd | input | 3 | Write-back destination |
| wb_wen | input | 1 | Write-back writes a register |
| rf_a | input | 16 | Register-file read, first source |
| rf_b | input | 16 | Register-file read, second source |
| mem_res | input | 16 | Value the memory stage hands to write-back |
| wb_data | input | 16 | Value being written back this cycle |
| fwd_a_sel | output | 2 | First operand select |
| fwd_b_sel | output | 2 | Second operand select |
| opnd_a | output | 16 | Forwarded first operand |
| opnd_b | output | 16 | Forwarded second operand |
| br_taken | output | 1 | Conditional branch taken |
| pc_sel | output | 2 | Program-counter source |
| pc_en | output | 1 | Program-counter load enable |
| ifid_hold | output | 1 | Hold fetch/decode register |
| ifid_nop | output | 1 | Load NOP into fetch/decode register |
| idex_bubble | output | 1 | Load bubble into decode/execute register |

## Verification
The hardest cases are those where several conditions overlap. One is a branch that would be taken but sits behind a stall. Another is a memory access that coincides with a redirect. A third is a branch whose outcome depends on a forwarded value that differs from the stale register-file read. Table vectors build each overlap directly, for example a zero write-back value over a non-zero register read. An exhaustive sweep of source and destination numbers then covers the forwarding priority, register 0 included.

// File: rtl/decode_hazard_unit.sv
module decode_hazard_unit #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_blt,
  input  logic          id_beq,
  input  logic          id_jr,
  input  logic          id_trap,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_access,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [DW-1:0] mem_res,
  input  logic [DW-1:0] wb_data,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic          br_taken,
  output logic [1:0]    pc_sel,
  output logic          pc_en,
  output logic          ifid_hold,
  output logic          ifid_nop,
  output logic          idex_bubble
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_WB  = 2'b10;

  localparam logic [1:0] PC_SEQ  = 2'b00;
  localparam logic [1:0] PC_BR   = 2'b01;
  localparam logic [1:0] PC_REG  = 2'b10;
  localparam logic [1:0] PC_ZERO = 2'b11;

  function automatic logic [1:0] pick(input logic [AW-1:0] src);
    if (mem_wen && mem_rd == src)     pick = SEL_MEM;
    else if (wb_wen && wb_rd == src)  pick = SEL_WB;
    else                              pick = SEL_RF;
  endfunction

  assign fwd_a_sel = pick(id_rs);
  assign fwd_b_sel = pick(id_rt);

  always_comb begin
    case (fwd_a_sel)
      SEL_MEM: opnd_a = mem_res;
      SEL_WB:  opnd_a = wb_data;
      default: opnd_a = rf_a;
    endcase
    case (fwd_b_sel)
      SEL_MEM: opnd_b = mem_res;
      SEL_WB:  opnd_b = wb_data;
      default: opnd_b = rf_b;
    endcase
  end

  logic stall, cond_hit, redirect;

  assign stall = ex_wen && ((id_use_rs && ex_rd == id_rs) ||
                            (id_use_rt && ex_rd == id_rt));

  assign cond_hit = (id_blt && opnd_a[DW-1]) || (id_beq && (opnd_a == '0));

  assign redirect = !stall && (id_trap || id_jr || cond_hit);

  always_comb begin
    pc_sel = PC_SEQ;
    if (!stall) begin
      if (id_trap)       pc_sel = PC_ZERO;
      else if (id_jr)    pc_sel = PC_REG;
      else if (cond_hit) pc_sel = PC_BR;
    end
  end

  assign br_taken    = !stall && !id_trap && !id_jr && cond_hit;
  assign pc_en       = !stall && (redirect || !mem_access);
  assign ifid_hold   = stall;
  assign ifid_nop    = !stall && (redirect || mem_access);
  assign idex_bubble = stall;
endmodule

// File: rtl/decode_hazard_chk.sv
module decode_hazard_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic [AW-1:0] id_rs,
  input logic          id_blt,
  input logic          id_beq,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_access,
  input logic [DW-1:0] mem_res,
  input logic [1:0]    fwd_a_sel,
  input logic [DW-1:0] opnd_a,
  input logic          br_taken,
  input logic [1:0]    pc_sel,
  input logic          pc_en,
  input logic          ifid_hold,
  input logic          ifid_nop,
  input logic          idex_bubble
);
  always_comb begin
    AST_FWD_PRIO: assert (!(mem_wen && mem_rd == id_rs) || fwd_a_sel == 2'b01) else $error("fwd prio"); // R1
    AST_FWD_VALUE: assert (fwd_a_sel != 2'b01 || opnd_a == mem_res) else $error("fwd value"); // R2
    AST_HOLD_NOP_EXCL: assert (!(ifid_hold && ifid_nop)) else $error("hold and nop"); // R3
    AST_STALL_FREEZE: assert (!idex_bubble || (!pc_en && ifid_hold)) else $error("stall freeze"); // R3
    AST_BLT_NEG: assert (!(br_taken && id_blt && !id_beq) || opnd_a[DW-1]) else $error("blt sign"); // R4
    AST_TAKEN_REDIRECT: assert (!br_taken || (pc_sel == 2'b01 && pc_en && ifid_nop)) else $error("taken"); // R5
    AST_MEM_FETCH_OFF: assert (!(mem_access && pc_sel == 2'b00 && !idex_bubble) || (!pc_en && ifid_nop)) else $error("mem"); // R7
    AST_STALL_NO_REDIRECT: assert (!idex_bubble || (!br_taken && pc_sel == 2'b00)) else $error("stall redirect"); // R8
  end
endmodule

bind decode_hazard_unit decode_hazard_chk #(.DW(DW), .AW(AW)) u_chk (
  .id_rs(id_rs), .id_blt(id_blt), .id_beq(id_beq),
  .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_access(mem_access), .mem_res(mem_res),
  .fwd_a_sel(fwd_a_sel), .opnd_a(opnd_a), .br_taken(br_taken), .pc_sel(pc_sel),
  .pc_en(pc_en), .ifid_hold(ifid_hold), .ifid_nop(ifid_nop), .idex_bubble(idex_bubble)
);

// File: tb/sim_decode_hazard_unit.sv
`timescale 1ns/1ps
module sim_decode_hazard_unit;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [2:0] id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic id_use_rs, id_use_rt, id_blt, id_beq, id_jr, id_trap;
  logic ex_wen, mem_wen, mem_access, wb_wen;
  logic [15:0] rf_a, rf_b, mem_res, wb_data;
  logic [1:0] fwd_a_sel, fwd_b_sel, pc_sel;
  logic [15:0] opnd_a, opnd_b;
  logic br_taken, pc_en, ifid_hold, ifid_nop, idex_bubble;

  decode_hazard_unit u0 (.*);

  int checks = 0;
  int fails = 0;

  typedef struct packed {
    logic [2:0] rs; logic [2:0] rt; logic urs; logic urt; logic [2:0] kind;
    logic [2:0] exrd; logic exw; logic [2:0] memrd; logic memw; logic macc;
    logic [2:0] wbrd; logic wbw; logic [15:0] rfa;
    logic [1:0] esa; logic [1:0] esb; logic [1:0] epc; logic [4:0] ectl; logic [3:0] req;
  } vec_t;

  // ectl = {pc_en, ifid_hold, ifid_nop, idex_bubble, br_taken}; kind 1 blt, 2 beq, 3 jr, 4 trap
  localparam vec_t TBL [20] = '{
    '{3'd0,3'd0,1'b0,1'b0,3'd0, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b10000,4'd9}, // R9
    '{3'd2,3'd3,1'b1,1'b1,3'd0, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd2,1'b1, 16'h0005, 2'd2,2'd0,2'd0,5'b10000,4'd1}, // R1
    '{3'd2,3'd3,1'b1,1'b1,3'd0, 3'd0,1'b0, 3'd3,1'b1,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd1,2'd0,5'b10000,4'd1}, // R1
    '{3'd4,3'd5,1'b1,1'b1,3'd0, 3'd0,1'b0, 3'd4,1'b1,1'b0, 3'd4,1'b1, 16'h0005, 2'd1,2'd0,2'd0,5'b10000,4'd1}, // R1
    '{3'd0,3'd0,1'b1,1'b1,3'd0, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b1, 16'h0005, 2'd2,2'd2,2'd0,5'b10000,4'd1}, // R1
    '{3'd1,3'd2,1'b1,1'b1,3'd0, 3'd1,1'b1, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b01010,4'd3}, // R3
    '{3'd1,3'd2,1'b0,1'b1,3'd0, 3'd1,1'b1, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b10000,4'd3}, // R3
    '{3'd1,3'd6,1'b0,1'b1,3'd0, 3'd6,1'b1, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b01010,4'd3}, // R3
    '{3'd1,3'd0,1'b1,1'b0,3'd1, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'hFFFE, 2'd0,2'd0,2'd1,5'b10101,4'd4}, // R4
    '{3'd1,3'd0,1'b1,1'b0,3'd1, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b10000,4'd4}, // R4
    '{3'd1,3'd0,1'b1,1'b0,3'd2, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0000, 2'd0,2'd0,2'd1,5'b10101,4'd4}, // R4
    '{3'd1,3'd0,1'b1,1'b0,3'd2, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0001, 2'd0,2'd0,2'd0,5'b10000,4'd4}, // R4
    '{3'd2,3'd0,1'b1,1'b0,3'd2, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd2,1'b1, 16'h0007, 2'd2,2'd0,2'd1,5'b10101,4'd2}, // R2
    '{3'd2,3'd0,1'b1,1'b0,3'd1, 3'd0,1'b0, 3'd2,1'b1,1'b0, 3'd0,1'b0, 16'h0001, 2'd1,2'd0,2'd1,5'b10101,4'd2}, // R2
    '{3'd3,3'd0,1'b1,1'b0,3'd3, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd2,5'b10100,4'd6}, // R6
    '{3'd0,3'd0,1'b0,1'b0,3'd4, 3'd0,1'b0, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd3,5'b10100,4'd6}, // R6
    '{3'd0,3'd0,1'b0,1'b0,3'd0, 3'd0,1'b0, 3'd0,1'b0,1'b1, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b00100,4'd7}, // R7
    '{3'd1,3'd0,1'b1,1'b0,3'd2, 3'd0,1'b0, 3'd0,1'b0,1'b1, 3'd0,1'b0, 16'h0000, 2'd0,2'd0,2'd1,5'b10101,4'd5}, // R5
    '{3'd1,3'd0,1'b1,1'b0,3'd2, 3'd1,1'b1, 3'd0,1'b0,1'b0, 3'd0,1'b0, 16'h0000, 2'd0,2'd0,2'd0,5'b01010,4'd8}, // R8
    '{3'd1,3'd0,1'b1,1'b0,3'd0, 3'd1,1'b1, 3'd0,1'b0,1'b1, 3'd0,1'b0, 16'h0005, 2'd0,2'd0,2'd0,5'b01010,4'd8}  // R8
  };

  function automatic logic [15:0] pickval(logic [1:0] s, logic [15:0] rf);
    return (s == 2'd1) ? mem_res : (s == 2'd2) ? wb_data : rf;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    {id_rs, id_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_use_rs, id_use_rt, id_blt, id_beq, id_jr, id_trap} = '0;
    {ex_wen, mem_wen, mem_access, wb_wen} = '0;
    rf_a = 16'h0005; rf_b = 16'h2222; mem_res = 16'h8001; wb_data = 16'h0000;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_in();
    @(negedge clk);
    // R9: idle state after bench reset
    check("R9 idle", {59'd0, pc_en, pc_sel, ifid_hold, ifid_nop, idex_bubble}, {59'd0, 1'b1, 2'b00, 3'b000});

    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      clear_in();
      id_rs = TBL[i].rs; id_rt = TBL[i].rt; id_use_rs = TBL[i].urs; id_use_rt = TBL[i].urt;
      id_blt = TBL[i].kind == 3'd1; id_beq = TBL[i].kind == 3'd2;
      id_jr = TBL[i].kind == 3'd3; id_trap = TBL[i].kind == 3'd4;
      ex_rd = TBL[i].exrd; ex_wen = TBL[i].exw; mem_rd = TBL[i].memrd; mem_wen = TBL[i].memw;
      mem_access = TBL[i].macc; wb_rd = TBL[i].wbrd; wb_wen = TBL[i].wbw; rf_a = TBL[i].rfa;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", TBL[i].req, i),
            {fwd_a_sel, fwd_b_sel, pc_sel, pc_en, ifid_hold, ifid_nop, idex_bubble, br_taken, opnd_a, opnd_b},
            {TBL[i].esa, TBL[i].esb, TBL[i].epc, TBL[i].ectl,
             pickval(TBL[i].esa, TBL[i].rfa), pickval(TBL[i].esb, 16'h2222)});
    end

    // R2: same-cycle write-back value flows straight to the operand
    @(posedge clk);
    clear_in();
    id_rs = 3'd5; wb_rd = 3'd5; wb_wen = 1'b1;
    for (int v = 0; v < 4; v++) begin
      @(posedge clk);
      wb_data = 16'h1234 + 16'(v * 16'h1111);
      @(negedge clk);
      check("R2 wb passthrough", {48'd0, opnd_a}, {48'd0, wb_data});
    end

    // R1: exhaustive forwarding priority sweep on the second operand
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++)
          for (int e = 0; e < 4; e++) begin
            logic [1:0] exp_sel;
            @(posedge clk);
            clear_in();
            id_rt = 3'(s); mem_rd = 3'(m); wb_rd = 3'(w);
            mem_wen = e[0]; wb_wen = e[1];
            exp_sel = (e[0] && m == s) ? 2'b01 : (e[1] && w == s) ? 2'b10 : 2'b00;
            @(negedge clk);
            check("R1 sweep", {62'd0, fwd_b_sel}, {62'd0, exp_sel});
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule